// File: doc/BRIEF.md
# ADC Calibration Sequencer and Result Corrector

This block sits between a delta-sigma modulator's decimation filter and the register file of a converter. It does two jobs. First, it runs the four calibration procedures: internal zero-scale, internal full-scale, system zero-scale and system full-scale. For each one it counts conversion-done pulses for as long as the present chop, filter and gain settings require. It then stores the last raw result of that interval as the offset or gain coefficient. Second, it corrects every raw result produced in a conversion mode with the stored coefficients and presents the result on a valid/ready output stream.

Software starts an operation by pulsing `mode_wr` with a 3-bit code on `mode_code`:

| Code | Operation |
|------|-----------|
| 000 | continuous conversion |
| 001 | single conversion |
| 010 | idle |
| 100 | internal zero-scale calibration |
| 101 | internal full-scale calibration |
| 110 | system zero-scale calibration |
| 111 | system full-scale calibration |

Code 011 is treated as idle. During an internal calibration, `mux_sel` steers the modulator to the on-chip reference: 1 selects the zero input and 2 selects the full-scale input. For all other operations `mux_sel` is 0, which selects the pins.

The output stream follows these back-pressure rules. `out_data` holds a word while `out_valid` is high and stays unchanged until a cycle in which `out_ready` is also high. A new corrected word can load in the same cycle that the held word is taken. A conversion that arrives while a word is held and not taken is discarded, and the held word is kept.

Top module: `cal_seq_corr`

## Requirements
- R1: After reset, both `offset_coef` and `gain_coef` are 0x800000, `not_rdy` is 1, `out_valid` is 0, `cal_err` is 0, `mux_sel` is 0, and the block is idle.
- R2: In continuous mode (000), each `conv_done` pulse produces one output word one cycle later. The word is 0x800000 + floor((raw − offset_coef) × gain_coef / 2^23), clamped to the range 0x000000 to 0xFFFFFF.
- R3: While `out_valid`=1 and `out_ready`=0, `out_data` stays stable. A conversion arriving in that state is dropped.
- R4: In single mode (001), the first accepted conversion produces one word and the block then goes idle. Later conversions produce nothing.
- R5: In idle mode (010), conversions produce no output.
- R6: A calibration start sets `not_rdy`=1. A zero-scale calibration ends on conversion pulse N, where N = 4 with chop off and sinc4 (`sinc3_sel`=0), N = 3 with chop off and sinc3, and N = 2 with chop on.
- R7: An internal full-scale calibration takes N pulses when `gain_sel`=0 (gain 1) and 2N pulses for any other gain.
- R8: A system full-scale calibration takes N pulses at every gain.
- R9: An internal full-scale request whose filter word is not a multiple of 16 sets `cal_err`. It leaves both coefficients and `not_rdy` unchanged and puts the block in idle. The next mode write clears `cal_err`.
- R10: On the final pulse of a calibration, the raw value of that pulse is written to `offset_coef` (zero-scale codes) or to `gain_coef` (full-scale codes). `not_rdy` then clears and the block goes idle.
- R11: `mux_sel` is 1 during an internal zero-scale calibration, 2 during an internal full-scale calibration, and 0 at all other times.
- R12: `dout_rdy` equals `not_rdy` while `cs_n`=0 and is 1 while `cs_n`=1. `not_rdy` clears when a word is loaded and is set again when that word is taken.
- R13: No output word is produced during a calibration.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low synchronous reset |
| mode_wr | input | 1 | one-cycle pulse that writes `mode_code` |
| mode_code | input | 3 | operation code |
| gain_sel | input | 3 | gain setting; 0 means gain 1 |
| chop_en | input | 1 | chop enable |
| sinc3_sel | input | 1 | 1 selects sinc3, 0 selects sinc4 |
| filt_word | input | 10 | output-rate filter word |
| conv_done | input | 1 | conversion-done pulse from the modulator |
| raw_data | input | 24 | raw result, valid together with `conv_done` |
| cs_n | input | 1 | chip select, active low |
| out_ready | input | 1 | downstream accepts `out_data` |
| out_valid | output | 1 | corrected word is available |
| out_data | output | 24 | corrected word |
| not_rdy | output | 1 | 1 while no fresh result or calibration is in progress |
| dout_rdy | output | 1 | ready line as seen on the serial pin |
| mux_sel | output | 2 | input select: 0 pins, 1 internal zero, 2 internal full |
| cal_err | output | 1 | last internal full-scale request was refused |
| offset_coef | output | 24 | offset coefficient |
| gain_coef | output | 24 | gain coefficient |

## Verification
The hardest case to reach is the boundary of a calibration interval. This is sharpest for an internal full-scale calibration at a gain above 1, where the interval doubles to eight pulses. The stimulus delivers conversion pulses one at a time and checks after each one that the coefficient and `not_rdy` have not yet changed; only the final pulse may update them. A refused request is driven with a filter word that is not a multiple of 16, followed by a full run of pulses, to show that no coefficient moves. A system full-scale calibration that stores a gain near 2 sets up the corrected outputs that clamp at both ends of the range.

// File: rtl/cal_pkg.sv
package cal_pkg;
  typedef enum logic [2:0] {
    MD_CONT   = 3'b000,
    MD_SINGLE = 3'b001,
    MD_IDLE   = 3'b010,
    MD_RSVD   = 3'b011,
    MD_IZS    = 3'b100,
    MD_IFS    = 3'b101,
    MD_SZS    = 3'b110,
    MD_SFS    = 3'b111
  } md_e;

  // conversion periods in one settling interval
  function automatic logic [2:0] settle_len(input logic chop, input logic sinc3);
    if (chop) return 3'd2;
    else if (sinc3) return 3'd3;
    else return 3'd4;
  endfunction

  function automatic logic is_cal(input md_e m);
    return m[2];
  endfunction
endpackage

// File: rtl/cal_timer.sv
module cal_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             abort,
  input  logic [CNT_W-1:0] len_in,
  input  logic             tick,
  output logic             busy,
  output logic             done
);
  logic [CNT_W-1:0] cnt_q, len_q;

  assign done = busy && tick && (cnt_q == len_q - CNT_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      cnt_q <= '0;
      len_q <= '0;
    end else if (start) begin
      busy  <= 1'b1;
      cnt_q <= '0;
      len_q <= len_in;
    end else if (abort) begin
      busy <= 1'b0;
    end else if (busy && tick) begin
      if (done) busy <= 1'b0;
      else cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  // R6
  cnt_in_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (cnt_q < len_q));

  // R7
  done_ends_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> !busy);
endmodule

// File: rtl/cal_corrector.sv
module cal_corrector #(
  parameter int DW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [DW-1:0] raw,
  input  logic [DW-1:0] offset,
  input  logic [DW-1:0] gain,
  input  logic          out_ready,
  output logic          out_valid,
  output logic [DW-1:0] out_data,
  output logic          load
);
  localparam int PW   = 2 * DW + 2;
  localparam int MIDV = 2 ** (DW - 1);
  localparam int MAXV = 2 ** DW - 1;

  logic signed [DW:0]   diff;
  logic signed [PW-1:0] prod, scaled, sum;
  logic [DW-1:0]        sat;

  always_comb begin
    diff   = $signed({1'b0, raw}) - $signed({1'b0, offset});
    prod   = PW'(diff) * PW'($signed({1'b0, gain}));
    scaled = prod >>> (DW - 1);
    sum    = scaled + PW'(MIDV);
    if (sum < 0) sat = '0;
    else if (sum > PW'(MAXV)) sat = '1;
    else sat = sum[DW-1:0];
  end

  assign load = in_valid && (!out_valid || out_ready);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (load) begin
      out_valid <= 1'b1;
      out_data  <= sat;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  // R3
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
endmodule

// File: rtl/cal_seq_corr.sv
module cal_seq_corr
  import cal_pkg::*;
#(
  parameter int DW    = 24,
  parameter int GW    = 3,
  parameter int FW    = 10,
  parameter int CNT_W = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mode_wr,
  input  logic [2:0]    mode_code,
  input  logic [GW-1:0] gain_sel,
  input  logic          chop_en,
  input  logic          sinc3_sel,
  input  logic [FW-1:0] filt_word,
  input  logic          conv_done,
  input  logic [DW-1:0] raw_data,
  input  logic          cs_n,
  input  logic          out_ready,
  output logic          out_valid,
  output logic [DW-1:0] out_data,
  output logic          not_rdy,
  output logic          dout_rdy,
  output logic [1:0]    mux_sel,
  output logic          cal_err,
  output logic [DW-1:0] offset_coef,
  output logic [DW-1:0] gain_coef
);
  localparam logic [DW-1:0] UNITY   = DW'(1) << (DW - 1);
  localparam logic [FW-1:0] FW_MASK = FW'(15);

  md_e              mode_q, code_e;
  logic             code_cal, refuse, t_start, t_abort, cal_busy, cal_done;
  logic             conv_mode, in_valid, corr_load, out_fire;
  logic [CNT_W-1:0] len_calc;

  assign code_e    = md_e'(mode_code);
  assign code_cal  = is_cal(code_e);
  assign refuse    = (code_e == MD_IFS) && ((filt_word & FW_MASK) != '0);
  assign t_start   = mode_wr && code_cal && !refuse;
  assign t_abort   = mode_wr && !t_start;
  assign len_calc  = ((code_e == MD_IFS) && (gain_sel != '0))
                     ? (CNT_W'(settle_len(chop_en, sinc3_sel)) << 1)
                     : CNT_W'(settle_len(chop_en, sinc3_sel));
  assign conv_mode = (mode_q == MD_CONT) || (mode_q == MD_SINGLE);
  assign in_valid  = conv_done && conv_mode && !mode_wr;
  assign out_fire  = out_valid && out_ready;

  cal_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .start(t_start), .abort(t_abort),
    .len_in(len_calc), .tick(conv_done), .busy(cal_busy), .done(cal_done)
  );

  cal_corrector #(.DW(DW)) u_corr (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .raw(raw_data),
    .offset(offset_coef), .gain(gain_coef), .out_ready(out_ready),
    .out_valid(out_valid), .out_data(out_data), .load(corr_load)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q      <= MD_IDLE;
      cal_err     <= 1'b0;
      offset_coef <= UNITY;
      gain_coef   <= UNITY;
    end else if (mode_wr) begin
      cal_err <= refuse;
      if (refuse) mode_q <= MD_IDLE;
      else if (code_e == MD_RSVD) mode_q <= MD_IDLE;
      else mode_q <= code_e;
    end else begin
      if (cal_done) begin
        mode_q <= MD_IDLE;
        if (mode_q == MD_IZS || mode_q == MD_SZS) offset_coef <= raw_data;
        else gain_coef <= raw_data;
      end
      if (corr_load && mode_q == MD_SINGLE) mode_q <= MD_IDLE;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) not_rdy <= 1'b1;
    else if (t_start) not_rdy <= 1'b1;
    else if ((cal_done && !mode_wr) || corr_load) not_rdy <= 1'b0;
    else if (out_fire) not_rdy <= 1'b1;
  end

  always_comb begin
    mux_sel = 2'd0;
    if (cal_busy && mode_q == MD_IZS) mux_sel = 2'd1;
    else if (cal_busy && mode_q == MD_IFS) mux_sel = 2'd2;
  end

  assign dout_rdy = cs_n ? 1'b1 : not_rdy;

  // R6
  busy_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cal_busy |-> not_rdy);

  // R9
  refused_keeps_coef_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_wr && refuse) |=> (cal_err && $stable(gain_coef) && $stable(offset_coef)));

  // R11
  mux_only_in_cal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mux_sel != 2'd0) |-> cal_busy);

  // R13
  no_data_in_cal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cal_busy |-> !corr_load);
endmodule

// File: tb/sim_cal_seq_corr.sv
`timescale 1ns/1ps
module sim_cal_seq_corr;
  logic clk = 1'b0, rst_n = 1'b0;
  logic mode_wr = 1'b0, chop_en = 1'b0, sinc3_sel = 1'b0, conv_done = 1'b0;
  logic cs_n = 1'b1, out_ready = 1'b1;
  logic [2:0] mode_code = 3'b010, gain_sel = 3'd0;
  logic [9:0] filt_word = 10'h060;
  logic [23:0] raw_data = '0;
  logic out_valid, not_rdy, dout_rdy, cal_err;
  logic [23:0] out_data, offset_coef, gain_coef;
  logic [1:0] mux_sel;

  int errors = 0, checks = 0;
  logic [23:0] exp_q[$];
  logic [23:0] m_off = 24'h800000, m_gain = 24'h800000;

  always #2.5 clk = ~clk;

  cal_seq_corr u0 (
    .clk(clk), .rst_n(rst_n), .mode_wr(mode_wr), .mode_code(mode_code),
    .gain_sel(gain_sel), .chop_en(chop_en), .sinc3_sel(sinc3_sel),
    .filt_word(filt_word), .conv_done(conv_done), .raw_data(raw_data),
    .cs_n(cs_n), .out_ready(out_ready), .out_valid(out_valid),
    .out_data(out_data), .not_rdy(not_rdy), .dout_rdy(dout_rdy),
    .mux_sel(mux_sel), .cal_err(cal_err), .offset_coef(offset_coef),
    .gain_coef(gain_coef)
  );

  function automatic logic [23:0] model(input logic [23:0] r, input logic [23:0] o,
                                        input logic [23:0] g);
    longint d, p;
    d = longint'(r) - longint'(o);
    p = (d * longint'(g)) >>> 23;
    p = p + 64'sd8388608;
    if (p < 0) return 24'h000000;
    if (p > 64'sd16777215) return 24'hFFFFFF;
    return p[23:0];
  endfunction

  task automatic check(input string req, input longint act, input longint exp_v);
    checks++;
    if (act != exp_v) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp_v);
    end
  endtask

  task automatic set_mode(input logic [2:0] c);
    @(negedge clk); mode_wr = 1'b1; mode_code = c;
    @(negedge clk); mode_wr = 1'b0;
  endtask

  // driver: pushes the expected corrected word when an output is due
  task automatic send_conv(input logic [23:0] v, input bit expect_out);
    if (expect_out) exp_q.push_back(model(v, m_off, m_gain));
    @(negedge clk); conv_done = 1'b1; raw_data = v;
    @(negedge clk); conv_done = 1'b0;
  endtask

  // monitor: compares each taken word against the scoreboard
  always @(negedge clk) begin
    if (rst_n && out_valid && out_ready) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R13/R5 unexpected word actual=%0h expected=none", out_data);
      end else begin
        logic [23:0] e;
        e = exp_q.pop_front();
        if (out_data !== e) begin
          errors++;
          $display("FAIL R2 actual=%0h expected=%0h", out_data, e);
        end
      end
    end
  end

  // runs a calibration, stepping one pulse at a time
  task automatic run_cal(input string req, input logic [2:0] c, input int n,
                         input logic [23:0] last_v, input logic [1:0] mux_exp);
    bit zero;
    zero = (c == 3'b100 || c == 3'b110);
    set_mode(c);
    check({req, " R6 start not_rdy"}, not_rdy, 1);
    check({req, " R11 mux"}, mux_sel, mux_exp);
    for (int i = 0; i < n - 1; i++) begin
      send_conv(24'h0F0F0F + 24'(i), 1'b0);
      check({req, " R10 coef held"}, zero ? offset_coef : gain_coef, zero ? m_off : m_gain);
      check({req, " R6 still busy"}, not_rdy, 1);
    end
    send_conv(last_v, 1'b0);
    if (zero) m_off = last_v; else m_gain = last_v;
    check({req, " R10 coef stored"}, zero ? offset_coef : gain_coef, last_v);
    check({req, " R10 ready"}, not_rdy, 0);
    check({req, " R11 mux released"}, mux_sel, 0);
  endtask

  initial begin
    #(5.0 * 100000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    check("R1 offset", offset_coef, 24'h800000);
    check("R1 gain", gain_coef, 24'h800000);
    check("R1 not_rdy", not_rdy, 1);
    check("R1 out_valid", out_valid, 0);
    check("R1 cal_err", cal_err, 0);
    check("R1 mux", mux_sel, 0);
    check("R12 cs high", dout_rdy, 1);
    // R5 idle ignores
    send_conv(24'h123456, 1'b0);
    check("R5 idle no output", out_valid, 0);
    // R2 continuous, identity coefficients
    cs_n = 1'b0;
    set_mode(3'b000);
    send_conv(24'h123456, 1'b1);
    check("R12 dout_rdy low on load", dout_rdy, 0);
    send_conv(24'h000000, 1'b1);
    send_conv(24'hFFFFFF, 1'b1);
    send_conv(24'h800000, 1'b1);
    @(negedge clk);
    check("R12 not_rdy after take", dout_rdy, 1);
    // R3 back-pressure
    out_ready = 1'b0;
    send_conv(24'h00AA55, 1'b1);
    send_conv(24'h55AA00, 1'b0);
    repeat (2) @(negedge clk);
    check("R3 held word", out_data, model(24'h00AA55, m_off, m_gain));
    check("R3 valid held", out_valid, 1);
    out_ready = 1'b1;
    repeat (3) @(negedge clk);
    check("R3 dropped word absent", exp_q.size(), 0);
    check("R3 no extra valid", out_valid, 0);
    // calibrations
    run_cal("R6 sys zero sinc4", 3'b110, 4, 24'h800100, 2'd0);
    send_conv(24'h222222, 1'b0);
    check("R10 idle after cal", out_valid, 0);
    sinc3_sel = 1'b1;
    run_cal("R6 int zero sinc3", 3'b100, 3, 24'h7FFF00, 2'd1);
    sinc3_sel = 1'b0; chop_en = 1'b1;
    run_cal("R6 sys zero chop", 3'b110, 2, 24'h800040, 2'd0);
    chop_en = 1'b0;
    run_cal("R7 int full gain1", 3'b101, 4, 24'h900000, 2'd2);
    gain_sel = 3'd3;
    run_cal("R7 int full gain8", 3'b101, 8, 24'h700000, 2'd2);
    run_cal("R8 sys full gain8", 3'b111, 4, 24'h400000, 2'd0);
    // R9 refused request
    filt_word = 10'h065;
    set_mode(3'b101);
    check("R9 err set", cal_err, 1);
    check("R9 not_rdy unchanged", not_rdy, 0);
    check("R11 no mux on refuse", mux_sel, 0);
    for (int i = 0; i < 8; i++) send_conv(24'hABCDEF, 1'b0);
    check("R9 gain unchanged", gain_coef, m_gain);
    check("R9 offset unchanged", offset_coef, m_off);
    filt_word = 10'h060;
    // R2 with stored coefficients
    set_mode(3'b000);
    check("R9 err cleared", cal_err, 0);
    send_conv(24'hC00000, 1'b1);
    send_conv(24'h100000, 1'b1);
    send_conv(24'h800040, 1'b1);
    // R2 clamping with gain near 2
    run_cal("R8 sys full large", 3'b111, 4, 24'hFFFFFF, 2'd0);
    set_mode(3'b000);
    send_conv(24'hFFFFFF, 1'b1);
    send_conv(24'h000000, 1'b1);
    send_conv(24'hA00000, 1'b1);
    // R4 single
    set_mode(3'b001);
    send_conv(24'h812345, 1'b1);
    send_conv(24'h833333, 1'b0);
    @(negedge clk);
    check("R4 single one word", exp_q.size(), 0);
    check("R4 no second word", out_valid, 0);
    cs_n = 1'b1;
    @(negedge clk);
    check("R12 cs high", dout_rdy, 1);
    repeat (3) @(negedge clk);
    check("R2 scoreboard drained", exp_q.size(), 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule